// File: doc/BRIEF.md
# Double-Buffered Clock Register Bank

This block sits between a byte-wide register bus and a free-running time-of-day counter. It presents eight byte registers: a control byte and seven time fields (seconds, minutes, hour, weekday, day of month, month, year). Software reads the time through a user-visible copy of the counter fields. It sets the time by staging new values in that same copy and committing them to the counter as a single transfer.

Two control bits govern the copy. The read bit freezes it, so that a multi-byte read gives one coherent moment while the counter keeps running. The write bit holds it for staging. Releasing the write bit makes the block issue a one-cycle load pulse, which carries the staged fields to the counter. When neither bit is set, the copy follows the counter on every one-second advance. The bank also stores the oscillator-stop and frequency-test flags and drives them out to the counter.

Top module: `clkbank_regs`

## Requirements
- R1: Register offsets are 0 control, 1 seconds, 2 minutes, 3 hour, 4 weekday, 5 day of month, 6 month, 7 year. After reset every register reads 0, and load_pulse, osc_stop and freq_test are 0.
- R2: In the control byte, bit 7 is the write (hold) bit and bit 6 is the read (freeze) bit. Control bits 5:0 always read 0, whatever was written.
- R3: While the read bit is 1 and the write bit is 0, the time registers keep their values and ignore cnt_tick and cnt_time.
- R4: A control write that clears the read bit while the write bit is 0 copies all seven fields from cnt_time at that clock edge. The new values are visible from the next cycle.
- R5: While the write bit is 1, writes to offsets 1–7 store into the time fields and cnt_tick has no effect on them.
- R6: A control write that clears a set write bit raises load_pulse for exactly the following cycle. During that cycle load_time holds the staged fields and cnt_tick is ignored.
- R7: Field widths are seconds 7, minutes 7, hour 6, weekday 3, day of month 6, month 5, year 8. Bits above a field's width read 0 (apart from the flags in R10).
- R8: With both control bits 0, each cnt_tick copies cnt_time into the time fields. Bit layout of cnt_time and load_time: seconds [6:0], minutes [13:7], hour [19:14], weekday [22:20], day of month [28:23], month [33:29], year [41:34].
- R9: With both control bits set, the write bit wins. Fields can be staged, and clearing only the write bit commits them while the copy stays frozen.
- R10: Bit 7 of offset 1 is the oscillator-stop flag and bit 6 of offset 4 is the frequency-test flag. Both are writable at any time, read back in place, and drive osc_stop and freq_test.
- R11: Writes to offsets 1–7 while the write bit is 0 leave the time fields unchanged. Only the R10 flags take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe, one byte per cycle |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| cnt_time | input | 42 | Current counter fields |
| cnt_tick | input | 1 | One-cycle pulse when the counter advances one second |
| load_pulse | output | 1 | One-cycle request to load load_time into the counter |
| load_time | output | 42 | Staged fields for the counter |
| osc_stop | output | 1 | Oscillator-stop flag |
| freq_test | output | 1 | Frequency-test flag |

## Verification
The assertions assume that bus_wr, bus_addr and bus_wdata are valid on every clock edge, that only one byte is written per cycle, and that cnt_tick is a single-cycle pulse. They also assume that the counter takes in load_time on the cycle load_pulse is high. The bench drives every input once per cycle, away from the clock edge. It mixes random writes to all offsets, including bytes with unused bits set, with random tick pulses and random counter values. Directed sequences cover the freeze, release, staging, commit and both-bits-set orderings.

// File: rtl/clkbank_pkg.sv
package clkbank_pkg;

    localparam int DW = 8;
    localparam int AW = 3;

    typedef struct packed {
        logic [7:0] year;
        logic [4:0] month;
        logic [5:0] date;
        logic [2:0] wday;
        logic [5:0] hour;
        logic [6:0] mins;
        logic [6:0] secs;
    } tfields_t;

    localparam int TW = $bits(tfields_t);

    typedef enum logic [AW-1:0] {
        OFS_CTRL  = 3'd0,
        OFS_SEC   = 3'd1,
        OFS_MIN   = 3'd2,
        OFS_HOUR  = 3'd3,
        OFS_WDAY  = 3'd4,
        OFS_DATE  = 3'd5,
        OFS_MONTH = 3'd6,
        OFS_YEAR  = 3'd7
    } ofs_e;

    localparam int BIT_HOLD   = 7;
    localparam int BIT_FREEZE = 6;
    localparam int BIT_OSC    = 7;
    localparam int BIT_FT     = 6;

    function automatic tfields_t put_field(tfields_t t, ofs_e o, logic [DW-1:0] d);
        tfields_t r;
        r = t;
        case (o)
            OFS_SEC:   r.secs  = d[6:0];
            OFS_MIN:   r.mins  = d[6:0];
            OFS_HOUR:  r.hour  = d[5:0];
            OFS_WDAY:  r.wday  = d[2:0];
            OFS_DATE:  r.date  = d[5:0];
            OFS_MONTH: r.month = d[4:0];
            OFS_YEAR:  r.year  = d;
            default:   r = t;
        endcase
        return r;
    endfunction

    function automatic logic [DW-1:0] get_field(tfields_t t, ofs_e o);
        logic [DW-1:0] r;
        case (o)
            OFS_SEC:   r = {1'b0, t.secs};
            OFS_MIN:   r = {1'b0, t.mins};
            OFS_HOUR:  r = {2'b0, t.hour};
            OFS_WDAY:  r = {5'b0, t.wday};
            OFS_DATE:  r = {2'b0, t.date};
            OFS_MONTH: r = {3'b0, t.month};
            OFS_YEAR:  r = t.year;
            default:   r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/clkbank_ctrl.sv
module clkbank_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic wr_ctrl,
    input  logic wd_hold,
    input  logic wd_freeze,
    output logic hold_o,
    output logic freeze_o,
    output logic commit_o,
    output logic refresh_o,
    output logic load_o
);
    logic hold_q, freeze_q, load_q;

    assign commit_o  = wr_ctrl && hold_q && !wd_hold;
    assign refresh_o = wr_ctrl && freeze_q && !hold_q && !wd_freeze && !wd_hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q   <= 1'b0;
            freeze_q <= 1'b0;
            load_q   <= 1'b0;
        end else begin
            load_q <= commit_o;
            if (wr_ctrl) begin
                hold_q   <= wd_hold;
                freeze_q <= wd_freeze;
            end
        end
    end

    assign hold_o   = hold_q;
    assign freeze_o = freeze_q;
    assign load_o   = load_q;

    AST_LOAD_AFTER_RELEASE: assert property (@(posedge clk) disable iff (rst)
        load_q |-> (!hold_q && $past(hold_q))); // R6
    AST_LOAD_SINGLE: assert property (@(posedge clk) disable iff (rst)
        load_q |=> !load_q); // R6

endmodule

// File: rtl/clkbank_shadow.sv
module clkbank_shadow
    import clkbank_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           wr_reg,
    input  ofs_e           ofs,
    input  logic [DW-1:0]  wdata,
    input  logic           hold,
    input  logic           freeze,
    input  logic           refresh,
    input  logic           load_busy,
    input  logic           tick,
    input  tfields_t       cnt,
    output tfields_t       user_o,
    output logic           osc_o,
    output logic           ft_o
);
    tfields_t user_q;
    logic     osc_q, ft_q;
    logic     stage_wr, track;

    assign stage_wr = wr_reg && (ofs != OFS_CTRL) && hold;
    assign track    = tick && !hold && !freeze && !load_busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            user_q <= '0;
            osc_q  <= 1'b0;
            ft_q   <= 1'b0;
        end else begin
            if (stage_wr)
                user_q <= put_field(user_q, ofs, wdata);
            else if (refresh || track)
                user_q <= cnt;
            if (wr_reg && ofs == OFS_SEC)
                osc_q <= wdata[BIT_OSC];
            if (wr_reg && ofs == OFS_WDAY)
                ft_q <= wdata[BIT_FT];
        end
    end

    assign user_o = user_q;
    assign osc_o  = osc_q;
    assign ft_o   = ft_q;

    AST_FREEZE_STABLE: assert property (@(posedge clk) disable iff (rst)
        (freeze && !hold && !refresh) |=> $stable(user_q)); // R3
    AST_HOLD_NO_TRACK: assert property (@(posedge clk) disable iff (rst)
        (hold && !(wr_reg && ofs != OFS_CTRL)) |=> $stable(user_q)); // R5
    AST_FLAGS_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (rst)
        !wr_reg |=> ($stable(osc_q) && $stable(ft_q))); // R10

endmodule

// File: rtl/clkbank_regs.sv
module clkbank_regs
    import clkbank_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_wr,
    input  logic [AW-1:0]        bus_addr,
    input  logic [DW-1:0]        bus_wdata,
    output logic [DW-1:0]        bus_rdata,
    input  logic [TW-1:0]        cnt_time,
    input  logic                 cnt_tick,
    output logic                 load_pulse,
    output logic [TW-1:0]        load_time,
    output logic                 osc_stop,
    output logic                 freq_test
);
    ofs_e     ofs;
    tfields_t cnt_f, user_f;
    logic     hold, freeze, commit, refresh, load_q, osc_q, ft_q;
    logic     wr_ctrl;

    assign ofs     = ofs_e'(bus_addr);
    assign cnt_f   = tfields_t'(cnt_time);
    assign wr_ctrl = bus_wr && (ofs == OFS_CTRL);

    clkbank_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .wr_ctrl   (wr_ctrl),
        .wd_hold   (bus_wdata[BIT_HOLD]),
        .wd_freeze (bus_wdata[BIT_FREEZE]),
        .hold_o    (hold),
        .freeze_o  (freeze),
        .commit_o  (commit),
        .refresh_o (refresh),
        .load_o    (load_q)
    );

    clkbank_shadow u_shadow (
        .clk       (clk),
        .rst       (rst),
        .wr_reg    (bus_wr),
        .ofs       (ofs),
        .wdata     (bus_wdata),
        .hold      (hold),
        .freeze    (freeze),
        .refresh   (refresh),
        .load_busy (load_q),
        .tick      (cnt_tick),
        .cnt       (cnt_f),
        .user_o    (user_f),
        .osc_o     (osc_q),
        .ft_o      (ft_q)
    );

    always_comb begin
        bus_rdata = get_field(user_f, ofs);
        case (ofs)
            OFS_CTRL: begin
                bus_rdata             = '0;
                bus_rdata[BIT_HOLD]   = hold;
                bus_rdata[BIT_FREEZE] = freeze;
            end
            OFS_SEC:  bus_rdata[BIT_OSC] = osc_q;
            OFS_WDAY: bus_rdata[BIT_FT]  = ft_q;
            default:  ;
        endcase
    end

    assign load_pulse = load_q;
    assign load_time  = user_f;
    assign osc_stop   = osc_q;
    assign freq_test  = ft_q;

    AST_CTRL_LOW_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == 3'd0) |-> (bus_rdata[5:0] == 6'd0)); // R2
    AST_MONTH_NARROW: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == 3'd6) |-> (bus_rdata[7:5] == 3'd0)); // R7
    AST_COMMIT_STABLE: assert property (@(posedge clk) disable iff (rst)
        load_pulse |-> $stable(load_time)); // R6
    AST_COMMIT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        commit |=> load_pulse); // R6

endmodule

// File: tb/clkbank_regs_tb.sv
`timescale 1ns/100ps
module clkbank_regs_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_wr;
    logic [2:0]  bus_addr;
    logic [7:0]  bus_wdata;
    logic [7:0]  bus_rdata;
    logic [41:0] cnt_time;
    logic        cnt_tick;
    logic        load_pulse;
    logic [41:0] load_time;
    logic        osc_stop;
    logic        freq_test;

    always #4 clk = ~clk;

    clkbank_regs u_dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt_time(cnt_time),
        .cnt_tick(cnt_tick), .load_pulse(load_pulse), .load_time(load_time),
        .osc_stop(osc_stop), .freq_test(freq_test)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference state built from the requirements
    logic [7:0] m_f [1:7];
    logic m_w, m_r, m_osc, m_ft, m_load;

    function automatic logic [7:0] fmask(int i);
        case (i)
            1, 2: return 8'h7F;
            3, 5: return 8'h3F;
            4:    return 8'h07;
            6:    return 8'h1F;
            default: return 8'hFF;
        endcase
    endfunction

    function automatic logic [7:0] fld(logic [41:0] c, int i);
        case (i)
            1: return {1'b0, c[6:0]};
            2: return {1'b0, c[13:7]};
            3: return {2'b0, c[19:14]};
            4: return {5'b0, c[22:20]};
            5: return {2'b0, c[28:23]};
            6: return {3'b0, c[33:29]};
            default: return c[41:34];
        endcase
    endfunction

    function automatic logic [41:0] mpack();
        return {m_f[7], m_f[6][4:0], m_f[5][5:0], m_f[4][2:0],
                m_f[3][5:0], m_f[2][6:0], m_f[1][6:0]};
    endfunction

    function automatic logic [7:0] exp_rd(int a);
        logic [7:0] v;
        if (a == 0) return {m_w, m_r, 6'b0};
        v = m_f[a];
        if (a == 1) v[7] = m_osc;
        if (a == 4) v[6] = m_ft;
        return v;
    endfunction

    task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic check_all(string tag);
        for (int a = 0; a < 8; a++) begin
            bus_addr = 3'(a);
            #0.5;
            chk(tag, 64'(bus_rdata), 64'(exp_rd(a)));
        end
        chk(tag, 64'(osc_stop), 64'(m_osc));
        chk(tag, 64'(freq_test), 64'(m_ft));
        chk(tag, 64'(load_pulse), 64'(m_load));
        if (m_load) chk(tag, 64'(load_time), 64'(mpack()));
    endtask

    // one clock: inputs set after the previous edge, model advanced at this edge
    task automatic cyc(string tag, logic wr, logic [2:0] a, logic [7:0] d,
                       logic tk, logic [41:0] c);
        logic wrc, commit, refresh;
        logic [7:0] nf [1:7];
        logic nw, nr, nosc, nft;
        bus_wr = wr; bus_addr = a; bus_wdata = d; cnt_tick = tk; cnt_time = c;
        wrc     = wr && a == 3'd0;
        commit  = wrc && m_w && !d[7];
        refresh = wrc && m_r && !m_w && !d[6] && !d[7];
        nf = m_f; nw = m_w; nr = m_r; nosc = m_osc; nft = m_ft;
        if (wr && a != 3'd0 && m_w)
            nf[a] = d & fmask(int'(a));
        else if (refresh || (tk && !m_w && !m_r && !m_load))
            for (int i = 1; i < 8; i++) nf[i] = fld(c, i);
        if (wr && a == 3'd1) nosc = d[7];
        if (wr && a == 3'd4) nft  = d[6];
        if (wrc) begin nw = d[7]; nr = d[6]; end
        @(posedge clk);
        #2;
        m_f = nf; m_w = nw; m_r = nr; m_osc = nosc; m_ft = nft; m_load = commit;
        bus_wr = 1'b0; cnt_tick = 1'b0;
        check_all(tag);
    endtask

    function automatic logic [41:0] rnd42();
        return {10'($urandom), $urandom};
    endfunction

    initial begin
        #(200000 * 8);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog got=running exp=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [41:0] c1, c2;
        void'($urandom(32'h5EED_1234));
        rst = 1'b1; bus_wr = 0; bus_addr = 0; bus_wdata = 0; cnt_tick = 0;
        cnt_time = 42'h2AB_CDEF_0123;
        for (int i = 1; i < 8; i++) m_f[i] = 8'h00;
        m_w = 0; m_r = 0; m_osc = 0; m_ft = 0; m_load = 0;
        repeat (3) @(posedge clk);
        #2; rst = 1'b0;
        check_all("R1");

        // R2: unused control bits dropped
        cyc("R2", 1, 3'd0, 8'h3F, 0, cnt_time);
        // R8: tracking on tick
        c1 = rnd42();
        cyc("R8", 0, 3'd0, 8'h00, 1, c1);
        // R3: freeze, then ticks with new values ignored
        cyc("R3", 1, 3'd0, 8'h40, 0, c1);
        c2 = rnd42();
        cyc("R3", 0, 3'd0, 8'h00, 1, c2);
        cyc("R3", 0, 3'd0, 8'h00, 1, rnd42());
        // R4: release refreshes without a tick
        c2 = rnd42();
        cyc("R4", 1, 3'd0, 8'h00, 0, c2);
        // R11 and R10: field write ignored, flags taken
        cyc("R11", 1, 3'd1, 8'hFF, 0, c2);
        cyc("R10", 1, 3'd4, 8'h7F, 0, c2);
        // R5 and R7: stage all fields with unused bits set, tick ignored
        cyc("R5", 1, 3'd0, 8'h80, 0, c2);
        for (int i = 1; i < 8; i++)
            cyc("R7", 1, 3'(i), 8'hFF - 8'(i), 0, c2);
        cyc("R5", 0, 3'd0, 8'h00, 1, rnd42());
        // R6: commit, tick during the pulse ignored
        cyc("R6", 1, 3'd0, 8'h00, 0, c2);
        cyc("R6", 0, 3'd0, 8'h00, 1, rnd42());
        cyc("R8", 0, 3'd0, 8'h00, 1, rnd42());
        // R9: both bits, write wins; commit while frozen
        cyc("R9", 1, 3'd0, 8'hC0, 0, rnd42());
        cyc("R9", 1, 3'd7, 8'h42, 1, rnd42());
        cyc("R9", 1, 3'd0, 8'h40, 0, rnd42());
        cyc("R9", 0, 3'd0, 8'h00, 1, rnd42());
        cyc("R9", 0, 3'd0, 8'h00, 1, rnd42());
        cyc("R4", 1, 3'd0, 8'h00, 0, rnd42());

        // random mix
        for (int n = 0; n < 3000; n++) begin
            int op;
            logic [7:0] d;
            op = int'($urandom_range(0, 9));
            if (op < 3)
                cyc("R8", 0, 3'($urandom), 8'($urandom), 1, rnd42());
            else if (op < 5) begin
                d = {2'($urandom), ($urandom_range(0, 3) == 0) ? 6'($urandom) : 6'd0};
                cyc("R2", 1, 3'd0, d, $urandom_range(0, 1) == 1, rnd42());
            end else
                cyc("R7", 1, 3'($urandom_range(1, 7)), 8'($urandom),
                    $urandom_range(0, 3) == 0, rnd42());
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule